// File: doc/BRIEF.md
# Peripheral Interrupt Expansion Controller

This controller concentrates eight maskable peripheral interrupt sources onto two CPU interrupt lines. Each source has an edge-triggered pending flag and an enable bit. Each CPU line is raised whenever a member source is both pending and enabled. When the CPU takes an interrupt, it fetches that line's vector from a fixed program address. The controller watches the program address bus during the acknowledge strobe to learn which line was taken. In that cycle it selects the highest-priority enabled pending member of that line and records that source's identifying code in a vector register. It also clears that source's pending flag.

A general interrupt service routine reads the vector register and branches to the handler for that one event. If the acknowledged line has no enabled pending member left by the time of the acknowledge, the register receives the phantom code 0000h. Software sets the enable mask and can discard pending events through a small write port.

Top module: `pie_ctrl`

## Requirements
- R1: After reset, every pending flag and every enable bit is 0, the vector register reads 0000h and both CPU lines are low.
- R2: A pending flag is set by a 0-to-1 transition of its request input. A request held high does not set the flag again after the flag has been cleared.
- R3: A CPU line is high whenever at least one of its member sources is pending with its enable bit set. A pending source whose enable bit is clear does not raise the line and is never selected.
- R4: Sources 0 to 4 belong to line 0, which is acknowledged at program address 000Ah. Sources 5 to 7 belong to line 1, which is acknowledged at 000Ch.
- R5: Within a line, the lowest-numbered enabled pending source wins the acknowledge.
- R6: The code loaded for each source, from source 0 to source 7, is 0005h, 0006h, 0007h, 0040h, 0041h, 0004h, 0001h and 0011h.
- R7: An acknowledge clears only the winning source's pending flag. Other pending flags are kept.
- R8: An acknowledge of a line with no enabled pending member loads 0000h.
- R9: In the cycle after an acknowledge, the acknowledged line is low. From the following cycle on, it is high again if enabled pending members remain.
- R10: The vector register changes only on an acknowledge. The strobe alone at an address that belongs to no line, or a line address without the strobe, changes neither the register nor any pending flag.
- R11: A write with cfg_sel=0 loads the enable mask from cfg_wdata. A write with cfg_sel=1 clears each pending flag whose cfg_wdata bit is 1. A 0 bit leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 8 | Peripheral request lines, bit n is source n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: enable mask, 1: pending clear |
| cfg_wdata | input | 8 | Configuration write data |
| ack_i | input | 1 | CPU interrupt acknowledge strobe |
| pab_i | input | 16 | CPU program address during acknowledge |
| cpu_int_o | output | 2 | Grouped CPU interrupt lines |
| vec_rd_o | output | 16 | Peripheral vector register read value |

## Verification
The embedded assertions check the following on every cycle:
- an edge sets its flag;
- an acknowledge or software clear removes the targeted flag;
- the acknowledged line drops for one cycle;
- an empty acknowledge gives the phantom code;
- the vector register is stable without an acknowledge;
- each line has at most one winner.

Only the bench scenarios can show some behaviours. These are the mapping of each source to its code and line, and the full priority order across all 256 pending patterns and all 256 enable masks. They also include that a held-high request does not re-arm, and that strobes at foreign addresses are ignored.

// File: rtl/pie_pkg.sv
// pie_pkg: shared constants, source tables and configuration encodings for
// the peripheral interrupt expansion controller.
// Assumes: sources are numbered in priority order (0 highest); group
// vector addresses are distinct.
package pie_pkg;
    localparam int SRC_N  = 8;
    localparam int GRP_N  = 2;
    localparam int ADDR_W = 16;
    localparam int VEC_W  = 16;

    typedef enum logic {
        CFG_ENABLE = 1'b0,
        CFG_CLEAR  = 1'b1
    } cfg_sel_e;

    // Identifying code loaded into the vector register for source i.
    function automatic logic [VEC_W-1:0] src_vec(input int i);
        case (i)
            0:       return 16'h0005;
            1:       return 16'h0006;
            2:       return 16'h0007;
            3:       return 16'h0040;
            4:       return 16'h0041;
            5:       return 16'h0004;
            6:       return 16'h0001;
            7:       return 16'h0011;
            default: return '0;
        endcase
    endfunction

    // CPU line that source i is routed to.
    function automatic int src_grp(input int i);
        return (i < 5) ? 0 : 1;
    endfunction

    // Program address the CPU drives when acknowledging line g.
    function automatic logic [ADDR_W-1:0] grp_addr(input int g);
        return (g == 0) ? 16'h000A : 16'h000C;
    endfunction
endpackage

// File: rtl/pie_pending.sv
// pie_pending: per-source rising-edge detector and pending flag.
// Assumes: requests are synchronous to clk; a new edge wins over a clear in
// the same cycle so that no event is lost.
module pie_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] req_q;
    logic [N-1:0] pend_q;

    // Edge detect against last cycle's request level.
    always_comb rise_o = req_i & ~req_q;

    // Track request level and pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_i;
            pend_q <= (pend_q & ~clr_i) | rise_o;
        end
    end

    assign pend_o = pend_q;

    // R2
    edge_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((pend_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/pie_group_arb.sv
// pie_group_arb: fixed-priority selector for one CPU line. Picks the
// lowest-numbered member source among enabled pending candidates.
// Assumes: cand_i already combines pending and enable.
module pie_group_arb #(
    parameter int N   = 8,
    parameter int GRP = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] win_o,
    output logic         any_o
);
    import pie_pkg::*;

    // Scan from lowest priority upward so the lowest index overwrites.
    always_comb begin
        win_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (src_grp(i) == GRP && cand_i[i]) begin
                win_o    = '0;
                win_o[i] = 1'b1;
            end
        end
        any_o = |win_o;
    end

    // R5
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_o));

    // R3
    winner_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_o & ~cand_i) == '0));
endmodule

// File: rtl/pie_ack_vec.sv
// pie_ack_vec: decodes the CPU acknowledge from the program address, loads
// the vector register, produces the pending-clear mask and the one-cycle
// line hold-off.
// Assumes: at most one line address matches; win_i rows are one-hot or 0.
module pie_ack_vec #(
    parameter int N      = 8,
    parameter int G      = 2,
    parameter int ADDR_W = 16,
    parameter int VEC_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_i,
    input  logic [ADDR_W-1:0]   pab_i,
    input  logic [G-1:0][N-1:0] win_i,
    output logic [G-1:0]        ack_grp_o,
    output logic [N-1:0]        clr_o,
    output logic [G-1:0]        hold_o,
    output logic [VEC_W-1:0]    vec_o
);
    import pie_pkg::*;

    logic [VEC_W-1:0] vec_q;
    logic [VEC_W-1:0] vec_nxt;
    logic [G-1:0]     hold_q;

    // Match the fetch address, pick the winner's code (0 when none).
    always_comb begin
        ack_grp_o = '0;
        clr_o     = '0;
        vec_nxt   = '0;
        for (int g = 0; g < G; g++) begin
            ack_grp_o[g] = ack_i && (pab_i == grp_addr(g));
            if (ack_grp_o[g]) begin
                clr_o = clr_o | win_i[g];
                for (int i = 0; i < N; i++) begin
                    if (win_i[g][i]) vec_nxt = vec_nxt | src_vec(i);
                end
            end
        end
    end

    // Vector register and per-line hold-off after acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            hold_q <= '0;
        end else begin
            if (|ack_grp_o) vec_q <= vec_nxt;
            hold_q <= ack_grp_o;
        end
    end

    assign vec_o  = vec_q;
    assign hold_o = hold_q;

    // R4
    one_line_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_grp_o));

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ack_grp_o) |=> $stable(vec_q));
endmodule

// File: rtl/pie_ctrl.sv
// pie_ctrl: peripheral interrupt expansion controller top. Holds the enable
// mask, combines pending flags per CPU line, and dispatches acknowledges.
// Assumes: a single clock domain; software writes and CPU acknowledges are
// synchronous single-cycle strobes.
module pie_ctrl #(
    parameter int N_SRC  = pie_pkg::SRC_N,
    parameter int N_GRP  = pie_pkg::GRP_N,
    parameter int ADDR_W = pie_pkg::ADDR_W,
    parameter int VEC_W  = pie_pkg::VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [N_SRC-1:0]  cfg_wdata,
    input  logic              ack_i,
    input  logic [ADDR_W-1:0] pab_i,
    output logic [N_GRP-1:0]  cpu_int_o,
    output logic [VEC_W-1:0]  vec_rd_o
);
    import pie_pkg::*;

    logic [N_SRC-1:0]             en_q;
    logic [N_SRC-1:0]             pend;
    logic [N_SRC-1:0]             rise;
    logic [N_SRC-1:0]             sw_clr;
    logic [N_SRC-1:0]             ack_clr;
    logic [N_SRC-1:0]             cand;
    logic [N_GRP-1:0][N_SRC-1:0]  win;
    logic [N_GRP-1:0]             grp_any;
    logic [N_GRP-1:0]             ack_grp;
    logic [N_GRP-1:0]             hold;

    // Enable mask register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  en_q <= '0;
        else if (cfg_we && cfg_sel == CFG_ENABLE)    en_q <= cfg_wdata;
    end

    // Software write-one-to-clear mask.
    always_comb sw_clr = (cfg_we && cfg_sel == CFG_CLEAR) ? cfg_wdata : '0;

    // Candidates for arbitration: pending and enabled.
    always_comb cand = pend & en_q;

    pie_pending #(.N(N_SRC)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (src_req_i),
        .clr_i  (sw_clr | ack_clr),
        .pend_o (pend),
        .rise_o (rise)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_arb
        pie_group_arb #(.N(N_SRC), .GRP(g)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand_i (cand),
            .win_o  (win[g]),
            .any_o  (grp_any[g])
        );
    end

    pie_ack_vec #(.N(N_SRC), .G(N_GRP), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_i     (ack_i),
        .pab_i     (pab_i),
        .win_i     (win),
        .ack_grp_o (ack_grp),
        .clr_o     (ack_clr),
        .hold_o    (hold),
        .vec_o     (vec_rd_o)
    );

    // Line is raised by any winner unless held off after an acknowledge.
    always_comb cpu_int_o = grp_any & ~hold;

    // R7
    ack_clears_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_clr) && !(|(rise & ack_clr))) |=> ((pend & $past(ack_clr)) == '0));

    // R8
    phantom_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_grp) && !(|(ack_grp & grp_any))) |=> (vec_rd_o == '0));

    // R9
    line_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_grp) |=> ((cpu_int_o & $past(ack_grp)) == '0));

    // R11
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we && cfg_sel == CFG_CLEAR) && !(|(rise & cfg_wdata)))
        |=> ((pend & $past(cfg_wdata)) == '0));
endmodule

// File: tb/pie_ctrl_tb.sv
module pie_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  src_req_i;
    logic        cfg_we;
    logic        cfg_sel;
    logic [7:0]  cfg_wdata;
    logic        ack_i;
    logic [15:0] pab_i;
    logic [1:0]  cpu_int_o;
    logic [15:0] vec_rd_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] m_pend;
    logic [7:0] m_en;

    always #5 clk = ~clk;

    pie_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req_i (src_req_i),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ack_i     (ack_i),
        .pab_i     (pab_i),
        .cpu_int_o (cpu_int_o),
        .vec_rd_o  (vec_rd_o)
    );

    function automatic logic [15:0] tb_code(input int i);
        logic [15:0] t [8] = '{16'h0005, 16'h0006, 16'h0007, 16'h0040,
                               16'h0041, 16'h0004, 16'h0001, 16'h0011};
        return t[i];
    endfunction

    function automatic logic [7:0] tb_gmask(input int g);
        return (g == 0) ? 8'h1F : 8'hE0;
    endfunction

    function automatic logic [15:0] tb_addr(input int g);
        return (g == 0) ? 16'h000A : 16'h000C;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
        if (sel == 1'b0) m_en = d;
        else             m_pend = m_pend & ~d;
    endtask

    task automatic pulse(input logic [7:0] m);
        src_req_i = m;
        tick();
        src_req_i = '0;
        tick();
        m_pend = m_pend | m;
    endtask

    task automatic check_lines(input string req);
        logic [1:0] e;
        for (int g = 0; g < 2; g++) e[g] = |(m_pend & m_en & tb_gmask(g));
        check(req, {30'd0, cpu_int_o}, {30'd0, e});
    endtask

    // Acknowledge line g; model R5/R6/R7/R8 and R9 drop/reassert.
    task automatic do_ack(input int g, input string req);
        logic [7:0]  c;
        logic [15:0] ev;
        c  = m_pend & m_en & tb_gmask(g);
        ev = 16'h0000;
        for (int i = 7; i >= 0; i--) if (c[i]) ev = tb_code(i);
        for (int i = 0; i < 8; i++) if (c[i]) begin m_pend[i] = 1'b0; break; end
        ack_i = 1'b1; pab_i = tb_addr(g);
        tick();
        ack_i = 1'b0; pab_i = '0;
        check(req, {16'd0, vec_rd_o}, {16'd0, ev});
        check("R9 line low after ack", {31'd0, cpu_int_o[g]}, 32'd0);
        tick();
        check("R9 line reassert", {31'd0, cpu_int_o[g]},
              {31'd0, |(m_pend & m_en & tb_gmask(g))});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] held;
        rst_n = 1'b0; src_req_i = '0; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_wdata = '0; ack_i = 1'b0; pab_i = '0;
        m_pend = '0; m_en = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 vector", {16'd0, vec_rd_o}, 32'd0);
        check("R1 lines", {30'd0, cpu_int_o}, 32'd0);
        // R1 enables cleared: a pending source raises nothing
        pulse(8'hFF);
        check("R1 enables clear", {30'd0, cpu_int_o}, 32'd0);
        cfg_write(1'b1, 8'hFF);

        // R3/R4/R5/R6/R7/R8: every pending pattern, all enabled
        cfg_write(1'b0, 8'hFF);
        for (int p = 0; p < 256; p++) begin
            pulse(p[7:0]);
            check_lines("R3 R4 line state");
            for (int g = 0; g < 2; g++)
                for (int k = 0; k < 6; k++) do_ack(g, "R6 R5 R8 vector");
        end

        // R3 masking: all pending, every enable mask
        for (int e = 0; e < 256; e++) begin
            cfg_write(1'b1, 8'hFF);
            cfg_write(1'b0, e[7:0]);
            pulse(8'hFF);
            check_lines("R3 masked lines");
            do_ack(0, "R3 R5 masked winner");
            do_ack(1, "R3 R5 masked winner");
        end
        cfg_write(1'b1, 8'hFF);
        cfg_write(1'b0, 8'hFF);

        // R11: write 0 leaves flags, write 1 clears
        pulse(8'h21);
        cfg_write(1'b1, 8'h00);
        check_lines("R11 clear zero no effect");
        cfg_write(1'b1, 8'h01);
        check_lines("R11 clear one");
        do_ack(0, "R11 cleared source not dispatched");
        do_ack(1, "R11 other source kept");

        // R2: held-high request does not re-latch
        src_req_i = 8'h04;
        tick(); tick();
        m_pend = m_pend | 8'h04;
        do_ack(0, "R2 first edge");
        tick();
        do_ack(0, "R2 no re-latch while held");
        src_req_i = '0;
        tick();

        // R10: foreign address and missing strobe are ignored
        pulse(8'h08);
        held = vec_rd_o;
        ack_i = 1'b1; pab_i = 16'h000B;
        tick();
        ack_i = 1'b0; pab_i = '0;
        check("R10 foreign address vector", {16'd0, vec_rd_o}, {16'd0, held});
        check_lines("R10 foreign address pending kept");
        pab_i = 16'h000A;
        tick();
        pab_i = '0;
        check("R10 no strobe vector", {16'd0, vec_rd_o}, {16'd0, held});
        check_lines("R10 no strobe pending kept");
        do_ack(0, "R10 R6 later ack");
        repeat (3) tick();
        check("R10 vector holds", {16'd0, vec_rd_o}, 32'h0040);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule